// File: doc/BRIEF.md
# Digital Rate Trim for a 32,768 Hz Timebase

This block divides a 32,768 Hz oscillator clock down to a one-pulse-per-second tick and corrects the average rate of that tick in the digital domain. It does not trim the crystal. The prescaler has two stages. The first stage divides by 256. The second stage counts those 256-cycle sub-periods into a full second. Above the prescaler, a seconds counter and a minute counter form a 64-minute correction cycle. During the active part of that cycle, the block can change the length of one second per minute. A positive trim shortens that second by one whole sub-period, which drops 256 input cycles. A negative trim stretches that second's first sub-period by half its length, which adds 128 input cycles.

The trim setting has two parts: a 5-bit magnitude and a direction bit. Both come from a control register outside the block. The block samples them once, at the origin of every correction cycle, so a change made mid-cycle only takes effect from the next cycle.

A test mode replaces the seconds LSB output with a 512 Hz square wave. The wave is taken from the first prescaler stage, so it runs at the same rate whatever the trim setting is. Technicians can measure the raw oscillator error on this output.

Top module: `rtcal_unit`

## Requirements
- R1: `cal_mag` (bits 4:0) is an unsigned magnitude from 0 to 31. `cal_speedup` = 1 selects adding counts (a faster clock) and 0 selects removing counts (a slower clock).
- R2: A second that is not corrected lasts 256 × `HI_DIV` input cycles, which is 32,768 with the default parameters. `tick_1hz` is high for exactly one input cycle at the end of each second.
- R3: A second corrected with `cal_speedup` = 1 lasts 256 input cycles less than an uncorrected second.
- R4: A second corrected with `cal_speedup` = 0 lasts 128 input cycles more than an uncorrected second.
- R5: With magnitude n, the corrected seconds are the first second of each of minutes 0 to 2n−1 of the 64-minute cycle. No other second is corrected, and a magnitude of 0 corrects none.
- R6: Relative to nominal, one correction cycle is shorter by 512·n input cycles when speeding up and longer by 256·n input cycles when slowing down.
- R7: The trim setting is sampled at the first input cycle of each correction cycle. A change made after that point does not alter the current cycle, and it applies fully to the next cycle.
- R8: While `freq_test` = 1, `sec_bit0` is a square wave that changes level every 32 input cycles (512 Hz at 32,768 Hz). It keeps this rate through stretched seconds and for any trim value.
- R9: While `freq_test` = 0, `sec_bit0` is the LSB of the count of seconds elapsed since reset. It changes on the input cycle after each `tick_1hz`.
- R10: While `rst_n` is low, every counter is held at zero and `tick_1hz` and `sec_bit0` are low. The first input cycle after release is the origin of a correction cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | 32,768 Hz oscillator clock; one edge per input cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_mag | input | 5 | Trim magnitude, 0 to 31 |
| cal_speedup | input | 1 | Trim direction: 1 adds counts, 0 removes counts |
| freq_test | input | 1 | Selects the 512 Hz test wave on `sec_bit0` |
| tick_1hz | output | 1 | One-cycle pulse at the end of each corrected second |
| sec_bit0 | output | 1 | Seconds LSB, or the 512 Hz test wave |

## Verification
Two events can land on the same input cycle. The first is the origin of a correction cycle, where the trim setting is captured. The second is the first sub-period boundary of minute 0, where that setting is used. To provoke this, the bench changes the trim inputs during a cycle and then times the seconds on both sides of the next origin. The seconds before the origin must follow the old value and the seconds after it must follow the new one. The test wave and the stretch also share cycles, because a stretched sub-period runs the first-stage counter past 255. The bench therefore times every level change of the test wave across a second stretched by the maximum magnitude.

// File: rtl/rtcal_pkg.sv
package rtcal_pkg;
  localparam int unsigned BASE_DIV    = 256;
  localparam int unsigned STRETCH_CYC = 128;
  localparam int unsigned LO_W        = 9;
  localparam int unsigned MAG_W       = 5;
  localparam int unsigned MIN_W       = 6;
  localparam int unsigned ACTIVE_MIN  = 62;

  // last count of the first-stage divider for this sub-period
  function automatic logic [LO_W-1:0] lo_last(input logic stretch);
    return stretch ? LO_W'(BASE_DIV + STRETCH_CYC - 1) : LO_W'(BASE_DIV - 1);
  endfunction

  // number of leading minutes of a cycle that carry a correction
  function automatic logic [MIN_W:0] span_minutes(input logic [MAG_W-1:0] mag);
    return {1'b0, mag, 1'b0};
  endfunction
endpackage

// File: rtl/rtcal_prescaler.sv
module rtcal_prescaler
  import rtcal_pkg::*;
#(
  parameter int unsigned HI_DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stretch_req,
  input  logic skip_req,
  output logic sec_tick,
  output logic sec_origin,
  output logic wave512
);
  localparam int unsigned HW = $clog2(HI_DIV + 1);

  logic [LO_W-1:0] lo_q;
  logic [HW-1:0]   hi_q;
  logic            first_sub;
  logic            lo_end;
  logic [HW:0]     hi_sum;
  logic            started_q;

  assign first_sub  = (hi_q == '0);
  assign lo_end     = (lo_q == lo_last(stretch_req && first_sub));
  assign hi_sum     = {1'b0, hi_q} + ((skip_req && first_sub) ? (HW+1)'(2) : (HW+1)'(1));
  assign sec_tick   = lo_end && (hi_sum >= (HW+1)'(HI_DIV));
  assign sec_origin = (lo_q == '0) && first_sub;
  assign wave512    = lo_q[5];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q      <= '0;
      hi_q      <= '0;
      started_q <= 1'b0;
    end else begin
      started_q <= 1'b1;
      if (lo_end) begin
        lo_q <= '0;
        hi_q <= sec_tick ? '0 : hi_sum[HW-1:0];
      end else begin
        lo_q <= lo_q + 1'b1;
      end
    end
  end

  // R4: the first stage only passes 255 inside a stretched first sub-period
  p_lo_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lo_q <= LO_W'(BASE_DIV + STRETCH_CYC - 1));
  p_stretch_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_q == LO_W'(BASE_DIV)) |-> (stretch_req && first_sub));
  // R8: the test wave changes level on every 32-cycle boundary
  p_wave_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && lo_q[4:0] == 5'd0) |-> (wave512 != $past(wave512)));
endmodule

// File: rtl/rtcal_sequencer.sv
module rtcal_sequencer
  import rtcal_pkg::*;
#(
  parameter int unsigned SEC_PER_MIN = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic             sec_origin,
  input  logic [MAG_W-1:0] cal_mag,
  input  logic             cal_speedup,
  output logic             stretch_req,
  output logic             skip_req,
  output logic             sec_par
);
  localparam int unsigned SW = $clog2(SEC_PER_MIN + 1);

  logic [SW-1:0]    sec_idx_q;
  logic [MIN_W-1:0] min_idx_q;
  logic [MAG_W-1:0] cap_mag_q;
  logic             cap_up_q;
  logic             at_origin;
  logic             modify;

  assign at_origin   = sec_origin && (sec_idx_q == '0) && (min_idx_q == '0);
  assign modify      = (sec_idx_q == '0) && ({1'b0, min_idx_q} < span_minutes(cap_mag_q));
  assign skip_req    = modify && cap_up_q;
  assign stretch_req = modify && !cap_up_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_idx_q <= '0;
      min_idx_q <= '0;
      cap_mag_q <= '0;
      cap_up_q  <= 1'b0;
      sec_par   <= 1'b0;
    end else begin
      if (at_origin) begin
        cap_mag_q <= cal_mag;
        cap_up_q  <= cal_speedup;
      end
      if (sec_tick) begin
        sec_par <= ~sec_par;
        if (sec_idx_q == SW'(SEC_PER_MIN - 1)) begin
          sec_idx_q <= '0;
          min_idx_q <= min_idx_q + 1'b1;
        end else begin
          sec_idx_q <= sec_idx_q + 1'b1;
        end
      end
    end
  end

  // R7: captured trim is frozen between cycle origins
  p_cap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !at_origin |=> ($stable(cap_mag_q) && $stable(cap_up_q)));
  // R5: corrections only in the first second of an active minute
  p_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    modify |-> (sec_idx_q == '0 && min_idx_q < MIN_W'(ACTIVE_MIN)));
  p_zero_mag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mag_q == '0) |-> !(skip_req || stretch_req));
  // R9: the seconds LSB flips after every tick
  p_par_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> (sec_par != $past(sec_par)));
endmodule

// File: rtl/rtcal_unit.sv
module rtcal_unit
  import rtcal_pkg::*;
#(
  parameter int unsigned HI_DIV      = 128,
  parameter int unsigned SEC_PER_MIN = 60
) (
  input  logic             clk_osc,
  input  logic             rst_n,
  input  logic [MAG_W-1:0] cal_mag,
  input  logic             cal_speedup,
  input  logic             freq_test,
  output logic             tick_1hz,
  output logic             sec_bit0
);
  logic stretch_req;
  logic skip_req;
  logic sec_origin;
  logic wave512;
  logic sec_par;

  rtcal_prescaler #(.HI_DIV(HI_DIV)) u_pre (
    .clk         (clk_osc),
    .rst_n       (rst_n),
    .stretch_req (stretch_req),
    .skip_req    (skip_req),
    .sec_tick    (tick_1hz),
    .sec_origin  (sec_origin),
    .wave512     (wave512)
  );

  rtcal_sequencer #(.SEC_PER_MIN(SEC_PER_MIN)) u_seq (
    .clk         (clk_osc),
    .rst_n       (rst_n),
    .sec_tick    (tick_1hz),
    .sec_origin  (sec_origin),
    .cal_mag     (cal_mag),
    .cal_speedup (cal_speedup),
    .stretch_req (stretch_req),
    .skip_req    (skip_req),
    .sec_par     (sec_par)
  );

  assign sec_bit0 = freq_test ? wave512 : sec_par;

  // R10: nothing ticks in the cycle at the cycle origin
  p_origin_quiet_r10: assert property (@(posedge clk_osc) disable iff (!rst_n)
    sec_origin |-> !tick_1hz);
endmodule

// File: tb/test_rtcal_unit.sv
module test_rtcal_unit;
  localparam int HI   = 2;
  localparam int NOM  = 256 * HI;
  localparam int NSEC = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] cal_mag = '0;
  logic       cal_speedup = 1'b0;
  logic       freq_test = 1'b0;
  logic       tick_1hz;
  logic       sec_bit0;

  int checks = 0;
  int errors = 0;
  int ticks  = 0;
  int cyc    = 0;

  // {direction, magnitude}
  localparam logic [5:0] VEC [4] = '{6'b0_00000, 6'b1_00001, 6'b0_00011, 6'b1_11111};

  rtcal_unit #(.HI_DIV(HI), .SEC_PER_MIN(1)) i_rtcal_unit (
    .clk_osc(clk), .rst_n(rst_n), .cal_mag(cal_mag), .cal_speedup(cal_speedup),
    .freq_test(freq_test), .tick_1hz(tick_1hz), .sec_bit0(sec_bit0)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int want_len(input int idx, input int mag, input bit up);
    if (idx < mag + mag) return up ? NOM - 256 : NOM + 128;
    return NOM;
  endfunction

  task automatic do_reset(input int mag, input bit up, input bit ft);
    @(negedge clk);
    rst_n = 1'b0; cal_mag = 5'(mag); cal_speedup = up; freq_test = ft;
    repeat (3) @(negedge clk);
    chk("R10 tick", int'(tick_1hz), 0);
    chk("R10 bit0", int'(sec_bit0), 0);
    rst_n = 1'b1;
    ticks = 0;
  endtask

  // time seconds [first, first+n) of the run
  task automatic time_secs(input int first, input int n, input int mag, input bit up,
                           input bit fresh, output int total);
    total = 0;
    for (int s = 0; s < n; s++) begin
      int cnt = (fresh && s == 0) ? 1 : 0;
      int idx = (first + s) % NSEC;
      do begin
        @(negedge clk);
        if (!tick_1hz) cnt++;
      end while (!tick_1hz);
      cnt++;
      chk("R9 parity", int'(sec_bit0), ticks % 2);
      ticks++;
      if (idx < mag + mag) chk(up ? "R3 short" : "R4 long", cnt, want_len(idx, mag, up));
      else chk(mag == 0 ? "R2 nominal" : "R5 untouched", cnt, want_len(idx, mag, up));
      total += cnt;
    end
  endtask

  initial begin
    int tot;
    int a;
    do_reset(0, 1'b0, 1'b0);

    // main vectors: a full correction cycle each
    foreach (VEC[v]) begin
      int mag = int'(VEC[v][4:0]);
      bit up  = VEC[v][5];
      do_reset(mag, up, 1'b0);
      time_secs(0, NSEC, mag, up, 1'b1, tot);
      chk("R1 R6 cycle", tot, up ? NSEC*NOM - 512*mag : NSEC*NOM + 256*mag);
    end

    // R7: change the setting after the origin, observe on both sides of the next one
    do_reset(2, 1'b1, 1'b0);
    time_secs(0, 1, 2, 1'b1, 1'b1, a);
    cal_mag = 5'd1; cal_speedup = 1'b0;
    time_secs(1, NSEC-1, 2, 1'b1, 1'b0, tot);
    chk("R7 old cycle", tot + a, NSEC*NOM - 1024);
    time_secs(0, 3, 1, 1'b0, 1'b0, tot);
    chk("R7 new cycle", tot, 3*NOM + 256);

    // R8: test wave across a maximally stretched second
    do_reset(31, 1'b0, 1'b1);
    begin
      logic prev;
      int   run;
      int   seen;
      @(negedge clk);
      prev = sec_bit0; run = 0; seen = 0;
      for (int k = 0; k < 720; k++) begin
        @(negedge clk);
        run++;
        if (sec_bit0 != prev) begin
          if (seen > 0) chk("R8 half period", run, 32);
          seen++;
          run = 0;
          prev = sec_bit0;
        end
      end
      chk("R8 edges seen", int'(seen >= 20), 1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule